// File: doc/BRIEF.md
# Trigger Statistics and Control Register Bank

This block sits beside a time-measurement readout and keeps its run statistics. It classifies incoming trigger strobes, counting valid triggers with and without timing, invalid triggers, timing triggers that arrive while an earlier trigger is still being served, spurious timing validations and the readouts those spoil. It watches the raw timing-trigger line for glitches that are too short to be real triggers. It measures how long the readout state machine sits idle or waits, in 10 ns units at a 5 ns clock. It also keeps a running total of empty channels.

The statistics and a small set of control fields are reached through a plain register bus. That bus has an 8-bit address, separate read and write strobes, and 32-bit data. The control fields drive the readout directly: analyser select, debug enable, trigger mode, window widths with their enable, and 64 channel enables. The readout state machine itself lives elsewhere. It reports its state class and debug byte on input pins.

Top module: `trig_stats_regbank`

## Requirements
- R1: After reset every statistics counter, every control field and the read data are zero.
- R2: A `trg_timing` pulse adds one to the valid count (0x84) and to the timing count (0x85). A `trg_notiming` pulse adds one to the valid count and to the no-timing count (0x86). A `trg_invalid` pulse adds one only to the invalid count (0x87).
- R3: A `trg_timing` pulse while `trg_busy` is high also adds one to the multi-trigger count (0x88).
- R4: Each `trg_spurious` pulse adds one to the spurious count (0x89). Each `rd_corrupt` pulse adds one to the wrong-readout count (0x8A).
- R5: A high pulse on `timing_line` that lasts fewer than 8 clock cycles adds one to the spike count (0x8B) when it falls. A pulse of 8 cycles or more adds nothing.
- R6: The idle time (0x8C) and the wait time (0x8D) each add one for every two clock cycles that `fsm_idle` or `fsm_wait` is high. Odd cycles carry over to the next stay in that state.
- R7: Address 0x81 reads `ch_empty[31:0]` and 0x82 reads `ch_empty[63:32]`. In each cycle that `empty_tally` is high, the total at 0x8E grows by the number of set bits in `ch_empty`.
- R8: Only the defined control bits are written and read back; every other bit stays zero.
  - 0xC0: analyser select in bits 3:0, debug enable in bit 4, trigger mode in bit 12.
  - 0xC1: pre-window in bits 10:0, post-window in bits 26:16, window enable in bit 31.
  - 0xC2 and 0xC3: channel enables 31:0 and 63:32.
  - 0x83 reads back both window widths at the same positions as 0xC1, without the enable bit.
  - 0x80 reads `fsm_dbg` in bits 7:0.
- R9: Counters are CNT_W bits wide (24 by default) and sit in the low bits of the read word; the higher bits read as zero. Counters saturate at all-ones instead of wrapping.
- R10: A read of any unmapped address returns zero with `bus_miss` high. Writes to addresses other than 0xC0 to 0xC3 change nothing.
- R11: Read data and `bus_ack` appear in the cycle after `bus_rd` is sampled. `bus_ack` is low when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5 ns clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | 8 | register address |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, one cycle after strobe |
| bus_ack | output | 1 | read data valid |
| bus_miss | output | 1 | read hit an unmapped address |
| trg_timing | input | 1 | valid timing trigger pulse |
| trg_notiming | input | 1 | valid trigger without timing pulse |
| trg_invalid | input | 1 | invalid trigger pulse |
| trg_busy | input | 1 | previous trigger not yet released |
| trg_spurious | input | 1 | timing validated where none expected |
| rd_corrupt | input | 1 | readout spoiled by a spurious trigger |
| timing_line | input | 1 | raw timing-trigger level |
| fsm_idle | input | 1 | readout machine in idle state |
| fsm_wait | input | 1 | readout machine in a wait state |
| fsm_dbg | input | 8 | readout machine debug byte |
| ch_empty | input | 64 | per-channel empty flags |
| empty_tally | input | 1 | add empty-flag count to total |
| la_sel | output | 4 | analyser signal select |
| dbg_en | output | 1 | debug mode enable |
| trig_mode | output | 1 | 1 = triggered, 0 = triggerless |
| win_pre | output | 11 | window width before trigger |
| win_post | output | 11 | window width after trigger |
| win_en | output | 1 | window enable |
| ch_enable | output | 64 | channel enables |

## Verification
The trigger classes are driven one at a time, then a timing trigger is driven with busy held high. This separates the shared valid count from the per-class counts and from the multi count. Timing-line pulses of 3, 7, 8 and 20 cycles straddle the spike threshold, so an off-by-one in the length compare shows. Idle stays of odd length prove the half-rate carry. Holding a strobe for thousands of cycles drives counters past their maximum and exposes wrapping. All-ones writes expose any reserved bit that leaks into the control registers.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int NUM_CH  = 64;
  localparam int NUM_CNT = 11;
  localparam int AMT_W   = $clog2(NUM_CH + 1);

  typedef enum logic [3:0] {
    CI_VALID   = 4'd0,
    CI_TIMING  = 4'd1,
    CI_NOTIME  = 4'd2,
    CI_INVALID = 4'd3,
    CI_MULTI   = 4'd4,
    CI_SPUR    = 4'd5,
    CI_BADRD   = 4'd6,
    CI_SPIKE   = 4'd7,
    CI_IDLE    = 4'd8,
    CI_WAIT    = 4'd9,
    CI_EMPTY   = 4'd10
  } cnt_idx_e;

  localparam logic [7:0] A_DBG    = 8'h80;
  localparam logic [7:0] A_EMPLO  = 8'h81;
  localparam logic [7:0] A_EMPHI  = 8'h82;
  localparam logic [7:0] A_WINRD  = 8'h83;
  localparam logic [7:0] A_CNT0   = 8'h84;
  localparam logic [7:0] A_CTRL   = 8'hC0;
  localparam logic [7:0] A_WIN    = 8'hC1;
  localparam logic [7:0] A_ENLO   = 8'hC2;
  localparam logic [7:0] A_ENHI   = 8'hC3;

  localparam logic [31:0] CTRL_MASK = 32'h0000_101F;
  localparam logic [31:0] WIN_MASK  = 32'h87FF_07FF;

  // number of set flags among the channels
  function automatic logic [AMT_W-1:0] count_ones(input logic [NUM_CH-1:0] v);
    logic [AMT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_CH; i++) n = n + AMT_W'(v[i]);
    return n;
  endfunction

  // true when an address falls on a statistics counter
  function automatic logic is_counter(input logic [7:0] a);
    return (a >= A_CNT0) && (a < A_CNT0 + 8'(NUM_CNT));
  endfunction
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W     = 24,
  parameter int AMT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     value
);
  logic [W:0] sum;

  always_comb sum = {1'b0, value} + {{(W + 1 - AMT_W){1'b0}}, amt};

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (sum[W]) value <= '1;
    else             value <= sum[W-1:0];
  end
endmodule

// File: rtl/spike_filter.sv
module spike_filter #(
  parameter int MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic spike
);
  localparam int LEN_W = $clog2(MIN_CYC + 1);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MIN_CYC);

  logic [LEN_W-1:0] run_len;
  logic             prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
      prev    <= 1'b0;
    end else begin
      prev <= level;
      if (!level)             run_len <= '0;
      else if (run_len < CAP) run_len <= run_len + 1'b1;
    end
  end

  assign spike = prev && !level && (run_len < CAP);
endmodule

// File: rtl/dwell_tick.sv
module dwell_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic tick
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph;

  assign tick = active && (ph == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      ph <= '0;
    else if (tick)   ph <= '0;
    else if (active) ph <= ph + 1'b1;
  end
endmodule

// File: rtl/trig_stats_regbank.sv
module trig_stats_regbank
  import tsr_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int SPIKE_CYC = 8,
  parameter int TIME_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              bus_miss,
  input  logic              trg_timing,
  input  logic              trg_notiming,
  input  logic              trg_invalid,
  input  logic              trg_busy,
  input  logic              trg_spurious,
  input  logic              rd_corrupt,
  input  logic              timing_line,
  input  logic              fsm_idle,
  input  logic              fsm_wait,
  input  logic [7:0]        fsm_dbg,
  input  logic [NUM_CH-1:0] ch_empty,
  input  logic              empty_tally,
  output logic [3:0]        la_sel,
  output logic              dbg_en,
  output logic              trig_mode,
  output logic [10:0]       win_pre,
  output logic [10:0]       win_post,
  output logic              win_en,
  output logic [NUM_CH-1:0] ch_enable
);
  localparam int PAD = 32 - CNT_W;

  // named events
  logic ev_valid, ev_multi, spike_evt, idle_tick, wait_tick;
  logic [AMT_W-1:0] empty_amt;

  assign ev_valid  = trg_timing | trg_notiming;
  assign ev_multi  = trg_timing & trg_busy;
  assign empty_amt = empty_tally ? count_ones(ch_empty) : '0;

  spike_filter #(.MIN_CYC(SPIKE_CYC)) u_spike (
    .clk(clk), .rst_n(rst_n), .level(timing_line), .spike(spike_evt));

  dwell_tick #(.DIV(TIME_DIV)) u_idle (
    .clk(clk), .rst_n(rst_n), .active(fsm_idle), .tick(idle_tick));

  dwell_tick #(.DIV(TIME_DIV)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(fsm_wait), .tick(wait_tick));

  // counter bank
  logic [AMT_W-1:0] cnt_amt [NUM_CNT];
  logic [CNT_W-1:0] cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_flat;

  always_comb begin
    cnt_amt[CI_VALID]   = AMT_W'(ev_valid);
    cnt_amt[CI_TIMING]  = AMT_W'(trg_timing);
    cnt_amt[CI_NOTIME]  = AMT_W'(trg_notiming);
    cnt_amt[CI_INVALID] = AMT_W'(trg_invalid);
    cnt_amt[CI_MULTI]   = AMT_W'(ev_multi);
    cnt_amt[CI_SPUR]    = AMT_W'(trg_spurious);
    cnt_amt[CI_BADRD]   = AMT_W'(rd_corrupt);
    cnt_amt[CI_SPIKE]   = AMT_W'(spike_evt);
    cnt_amt[CI_IDLE]    = AMT_W'(idle_tick);
    cnt_amt[CI_WAIT]    = AMT_W'(wait_tick);
    cnt_amt[CI_EMPTY]   = empty_amt;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    sat_counter #(.W(CNT_W), .AMT_W(AMT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .amt(cnt_amt[g]), .value(cnt_val[g]));
    assign cnt_flat[g] = cnt_val[g];
  end

  // control registers
  logic [31:0] ctrl_reg, win_reg;
  logic [NUM_CH-1:0] en_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_reg <= '0;
      win_reg  <= '0;
      en_reg   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: ctrl_reg      <= bus_wdata & CTRL_MASK;
        A_WIN:  win_reg       <= bus_wdata & WIN_MASK;
        A_ENLO: en_reg[31:0]  <= bus_wdata;
        A_ENHI: en_reg[63:32] <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign la_sel    = ctrl_reg[3:0];
  assign dbg_en    = ctrl_reg[4];
  assign trig_mode = ctrl_reg[12];
  assign win_pre   = win_reg[10:0];
  assign win_post  = win_reg[26:16];
  assign win_en    = win_reg[31];
  assign ch_enable = en_reg;

  // read path
  logic [31:0] rd_mux;
  logic        rd_hit;
  logic [3:0]  cnt_sel;

  assign cnt_sel = bus_addr[3:0] - 4'd4;

  always_comb begin
    rd_hit = 1'b1;
    rd_mux = '0;
    if (is_counter(bus_addr)) begin
      rd_mux = {{PAD{1'b0}}, cnt_val[cnt_sel]};
    end else begin
      case (bus_addr)
        A_DBG:   rd_mux = {24'h0, fsm_dbg};
        A_EMPLO: rd_mux = ch_empty[31:0];
        A_EMPHI: rd_mux = ch_empty[63:32];
        A_WINRD: rd_mux = {5'h0, win_reg[26:16], 5'h0, win_reg[10:0]};
        A_CTRL:  rd_mux = ctrl_reg;
        A_WIN:   rd_mux = win_reg;
        A_ENLO:  rd_mux = en_reg[31:0];
        A_ENHI:  rd_mux = en_reg[63:32];
        default: rd_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_ack   <= 1'b0;
      bus_miss  <= 1'b0;
    end else begin
      bus_ack   <= bus_rd;
      bus_miss  <= bus_rd & ~rd_hit;
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/trig_stats_chk.sv
module trig_stats_chk
  import tsr_pkg::*;
#(
  parameter int W = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_rd,
  input logic                      bus_ack,
  input logic                      bus_miss,
  input logic [31:0]               bus_rdata,
  input logic                      timing_line,
  input logic                      spike_evt,
  input logic [31:0]               ctrl_reg,
  input logic [31:0]               win_reg,
  input logic [NUM_CNT-1:0][W-1:0] cnts
);
  // R11
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_ack);

  // R11
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_ack);

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_miss |-> (bus_ack && bus_rdata == 32'h0));

  // R5
  spike_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spike_evt |-> ($past(timing_line) && !timing_line));

  // R2
  valid_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnts[CI_VALID] >= cnts[CI_TIMING]) && (cnts[CI_VALID] >= cnts[CI_NOTIME]));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_reg & ~CTRL_MASK) == 32'h0) && ((win_reg & ~WIN_MASK) == 32'h0));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_mono
    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnts[g] >= $past(cnts[g]));
  end
endmodule

bind trig_stats_regbank trig_stats_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_ack(bus_ack),
  .bus_miss(bus_miss), .bus_rdata(bus_rdata), .timing_line(timing_line),
  .spike_evt(spike_evt), .ctrl_reg(ctrl_reg), .win_reg(win_reg),
  .cnts(cnt_flat));

// File: tb/trig_stats_regbank_test.sv
module trig_stats_regbank_test;
  localparam int CLK_PERIOD = 5;
  localparam int CW = 12;
  localparam logic [31:0] CMAX = (32'h1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_ack, bus_miss;
  logic trg_timing = 0, trg_notiming = 0, trg_invalid = 0, trg_busy = 0;
  logic trg_spurious = 0, rd_corrupt = 0, timing_line = 0;
  logic fsm_idle = 0, fsm_wait = 0, empty_tally = 0;
  logic [7:0] fsm_dbg = 0;
  logic [63:0] ch_empty = 0;
  logic [3:0] la_sel;
  logic dbg_en, trig_mode, win_en;
  logic [10:0] win_pre, win_post;
  logic [63:0] ch_enable;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  trig_stats_regbank #(.CNT_W(CW)) uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic ack, output logic miss);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    d = bus_rdata; ack = bus_ack; miss = bus_miss;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d; logic k, m;
    rd(a, d, k, m);
    check(req, d, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic k, m;
    for (int a = 8'h84; a <= 8'h8E; a++) rd_chk("R1 counter", 8'(a), 0);
    rd_chk("R1 ctrl", 8'hC0, 0);
    check("R1 outputs", {la_sel, dbg_en, trig_mode, win_en, win_pre, win_post}, 0);
    check("R1 enables", ch_enable, 0);
    @(negedge clk);
    check("R11 ack idle", bus_ack, 0);
    rd(8'h80, d, k, m);
    check("R11 ack after read", k, 1);
  endtask

  task automatic t_classes();
    @(negedge clk); trg_timing = 1; @(negedge clk); trg_timing = 0;
    @(negedge clk); trg_notiming = 1; @(negedge clk); trg_notiming = 0;
    @(negedge clk); trg_invalid = 1; @(negedge clk); trg_invalid = 0;
    rd_chk("R2 valid", 8'h84, 2);
    rd_chk("R2 timing", 8'h85, 1);
    rd_chk("R2 notiming", 8'h86, 1);
    rd_chk("R2 invalid", 8'h87, 1);
    rd_chk("R3 no multi when idle", 8'h88, 0);
  endtask

  task automatic t_multi();
    @(negedge clk); trg_busy = 1; trg_timing = 1;
    @(negedge clk); trg_timing = 0;
    @(negedge clk); trg_notiming = 1;
    @(negedge clk); trg_notiming = 0; trg_busy = 0;
    rd_chk("R3 multi", 8'h88, 1);
    rd_chk("R3 timing", 8'h85, 2);
    rd_chk("R3 valid", 8'h84, 4);
  endtask

  task automatic t_spur();
    repeat (2) begin @(negedge clk); trg_spurious = 1; @(negedge clk); trg_spurious = 0; end
    @(negedge clk); rd_corrupt = 1; @(negedge clk); rd_corrupt = 0;
    rd_chk("R4 spurious", 8'h89, 2);
    rd_chk("R4 wrong readout", 8'h8A, 1);
  endtask

  task automatic pulse_line(int n);
    @(negedge clk); timing_line = 1;
    repeat (n) @(negedge clk);
    timing_line = 0;
    @(negedge clk);
  endtask

  task automatic t_spike();
    pulse_line(3);  rd_chk("R5 3-cycle", 8'h8B, 1);
    pulse_line(7);  rd_chk("R5 7-cycle", 8'h8B, 2);
    pulse_line(8);  rd_chk("R5 8-cycle ignored", 8'h8B, 2);
    pulse_line(20); rd_chk("R5 long ignored", 8'h8B, 2);
  endtask

  task automatic t_dwell();
    @(negedge clk); fsm_idle = 1; repeat (5) @(negedge clk); fsm_idle = 0;
    rd_chk("R6 idle 5", 8'h8C, 2);
    @(negedge clk); fsm_idle = 1; repeat (3) @(negedge clk); fsm_idle = 0;
    rd_chk("R6 idle carry", 8'h8C, 4);
    @(negedge clk); fsm_wait = 1; repeat (4) @(negedge clk); fsm_wait = 0;
    rd_chk("R6 wait 4", 8'h8D, 2);
  endtask

  task automatic t_empty();
    @(negedge clk); ch_empty = 64'h8000_0001_0000_00F0;
    rd_chk("R7 low flags", 8'h81, 32'h0000_00F0);
    rd_chk("R7 high flags", 8'h82, 32'h8000_0001);
    @(negedge clk); empty_tally = 1; @(negedge clk); empty_tally = 0;
    rd_chk("R7 total", 8'h8E, 6);
    @(negedge clk); empty_tally = 1; @(negedge clk); empty_tally = 0;
    rd_chk("R7 total twice", 8'h8E, 12);
  endtask

  task automatic t_ctrl();
    wr(8'hC0, 32'hFFFF_FFFF);
    rd_chk("R8 ctrl mask", 8'hC0, 32'h0000_101F);
    check("R8 ctrl fields", {la_sel, dbg_en, trig_mode}, 6'h3F);
    wr(8'hC1, 32'hFFFF_FFFF);
    rd_chk("R8 win mask", 8'hC1, 32'h87FF_07FF);
    wr(8'hC1, 32'h0015_0023);
    rd_chk("R8 win status", 8'h83, 32'h0015_0023);
    check("R8 win fields", {win_en, win_post, win_pre}, {1'b0, 11'h015, 11'h023});
    wr(8'hC2, 32'hA5A5_0F0F);
    wr(8'hC3, 32'h1234_5678);
    check("R8 enables", ch_enable, 64'h1234_5678_A5A5_0F0F);
    @(negedge clk); fsm_dbg = 8'h5C;
    rd_chk("R8 debug byte", 8'h80, 32'h5C);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic k, m;
    rd(8'h90, d, k, m);
    check("R10 unmapped data", d, 0);
    check("R10 miss flag", {k, m}, 2'b11);
    rd(8'h84, d, k, m);
    check("R10 mapped no miss", m, 0);
    wr(8'h84, 32'h0000_0777);
    wr(8'h90, 32'hFFFF_FFFF);
    rd_chk("R10 counter write ignored", 8'h84, 4);
    rd_chk("R10 ctrl untouched", 8'hC0, 32'h0000_101F);
  endtask

  task automatic t_sat();
    @(negedge clk); trg_spurious = 1; repeat (4100) @(negedge clk); trg_spurious = 0;
    rd_chk("R9 spurious saturates", 8'h89, CMAX);
    @(negedge clk); ch_empty = '1; empty_tally = 1;
    repeat (70) @(negedge clk); empty_tally = 0;
    rd_chk("R9 empty saturates", 8'h8E, CMAX);
    @(negedge clk); trg_spurious = 1; @(negedge clk); trg_spurious = 0;
    rd_chk("R9 stays at max", 8'h89, CMAX);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_classes();
    t_multi();
    t_spur();
    t_spike();
    t_dwell();
    t_empty();
    t_ctrl();
    t_unmapped();
    t_sat();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule